// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs an asynchronous static-memory bus with up to four chip-select banks. A host issues one bus cycle at a time through a valid/ready request port that carries an address, write data, byte strobes and a read/write flag. The block decodes the address into a bank and then plays out a bus cycle. That cycle is built from five phases whose lengths come from the bank's own packed timing word. When the cycle is over, the block returns a one-cycle completion pulse with the read data.

A write-only configuration port holds two kinds of setting. A shared attribute register gives each bank a 4-bit nibble that selects data width, address granularity, external wait and byte lanes. Each bank also has a 32-bit timing word. A bus cycle copies its bank's timing word and attribute nibble when it is accepted, so software may rewrite either one at any time without disturbing a cycle already running. Page-mode fields are stored in the timing word but have no effect on the bus.

Top module: `static_bus_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, every chip select, the output enable, the write enable and both byte-lane strobes are high, the data bus is not driven, the request port is ready and no completion is reported.
- R2: A request to byte address 0x0400_0000 + n*0x0100_0000 + x, with 0 <= n < 4 and x below 0x0100_0000, selects bank n. Only bit n of the chip-select bus ever goes low for that cycle.
- R3: Accept the request at clock edge 0, and let a, c, t, h and g be the address setup, chip-select setup, access, chip-select hold and address hold fields. The read cycle then runs in this order: address only for a cycles; chip select low for c cycles; output enable low for t+1 cycles; chip select alone low for h cycles; address only for g cycles. The completion pulse follows in the next cycle, and the address stays stable while chip select is low.
- R4: Within the timing word, a sits in bits 31:28, c in 27:24, t in 20:16, h in 15:12 and g in 11:8. Bits 23:21 and 7:0 are stored but have no effect on bus timing.
- R5: A value of zero in a, c, h or g removes that phase entirely. A value of zero in t leaves a single-cycle strobe.
- R6: A write cycle uses the same phase order, with the write enable in place of the output enable. The output enable stays high, and the write data is driven on every cycle in which chip select is low.
- R7: Attribute nibble n occupies bits 4n+3:4n of the attribute register. Bit 0 of the nibble set means a 16-bit bus. Bit 0 clear means an 8-bit bus: the upper byte is driven as zero on writes and returned as zero on reads.
- R8: Nibble bit 1 set puts the byte offset x on the memory address. When it is clear, the memory address is x shifted right by one.
- R9: When nibble bit 2 is set, the last strobe cycle repeats for as long as the wait input is high. When bit 2 is clear, the wait input is ignored.
- R10: When nibble bit 3 is set, the byte-lane strobes equal the inverted request byte strobes while chip select is low. At all other times, and always when bit 3 is clear, both strobes stay high.
- R11: On the configuration port, byte offset 0x00 writes the attribute register and offset 0x04 + 4n writes bank n's timing word. Writes to any other offset change nothing.
- R12: A cycle keeps the timing word and attribute nibble it copied when it was accepted, even if software rewrites them while the cycle runs.
- R13: A request outside the four bank windows starts no bus activity. It completes in the cycle after acceptance with read data zero.
- R14: After reset every timing word reads as 8/8/31/8/8, for a 64-cycle bus cycle. The presets 1/1/27/1/1 and 1/1/11/1/1 give 32-cycle and 16-cycle bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | High when a request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte strobes, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| mem_addr | output | 24 | Memory address |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte-lane strobes |
| mem_dout | output | 16 | Data driven toward memory |
| mem_dout_en | output | 1 | High while mem_dout is to be driven |
| mem_din | input | 16 | Data returned from memory |
| mem_wait | input | 1 | External wait, high = stretch the access |

## Verification
The hardest case to reach from the ports is a timing-word rewrite that lands in the middle of a running cycle. It has to arrive after the old word was copied and before the cycle ends, so the edge it hits must be known exactly. The bench therefore drives configuration writes from inside its per-cycle monitor loop, at a chosen cycle offset after acceptance. It then measures both the cycle in flight and the next one. The wait stretch is placed the same way: the wait input is released on a strobe-cycle count the bench derives from the access field, so the exact number of added cycles can be checked.

// File: rtl/static_bus_timer.sv
module static_bus_timer #(
  parameter int          NBANK        = 4,
  parameter int          DW           = 16,
  parameter int          WIN_BITS     = 24,
  parameter int          CFG_AW       = 8,
  parameter int          CNT_W        = 5,
  parameter logic [31:0] BASE_ADDR    = 32'h0400_0000,
  parameter int          ATTR_OFS     = 0,
  parameter int          TIMING_OFS   = 4,
  parameter logic [31:0] RESET_TIMING = 32'h881F_8800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [DW/8-1:0]     req_be,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [WIN_BITS-1:0] mem_addr,
  output logic [NBANK-1:0]    mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DW/8-1:0]     mem_be_n,
  output logic [DW-1:0]       mem_dout,
  output logic                mem_dout_en,
  input  logic [DW-1:0]       mem_din,
  input  logic                mem_wait
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int HALF   = DW / 2;
  localparam int SEL_LO = WIN_BITS + BANK_W;

  typedef enum logic [2:0] {PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_CSH, PH_AH} phase_t;

  logic [4*NBANK-1:0] attr_q;
  logic [31:0]        tword_q [NBANK];
  phase_t             ph_q, nxt_ph;
  logic [CNT_W-1:0]   cnt_q, nxt_cnt;
  logic [31:0]        tim_l, src_t;
  logic [3:0]         attr_l;
  logic [BANK_W-1:0]  bank_l;
  logic               wr_l;
  logic [DW/8-1:0]    be_l;
  logic [BANK_W-1:0]  req_bank;
  logic               req_hit, cs_on, advance;
  logic [3:0]         req_attr;
  logic               unused_fields;

  assign req_bank = req_addr[WIN_BITS +: BANK_W];
  assign req_hit  = req_addr[31:SEL_LO] == BASE_ADDR[31:SEL_LO];
  assign req_attr = attr_q[4*req_bank +: 4];
  assign src_t    = (ph_q == PH_IDLE) ? tword_q[req_bank] : tim_l;
  assign unused_fields = ^{tim_l[23:21], tim_l[7:0]};

  always_comb begin
    case (ph_q)
      PH_IDLE: nxt_ph = (src_t[31:28] != 0) ? PH_ASU : (src_t[27:24] != 0) ? PH_CSU : PH_ACC;
      PH_ASU:  nxt_ph = (src_t[27:24] != 0) ? PH_CSU : PH_ACC;
      PH_CSU:  nxt_ph = PH_ACC;
      PH_ACC:  nxt_ph = (src_t[15:12] != 0) ? PH_CSH : (src_t[11:8] != 0) ? PH_AH : PH_IDLE;
      PH_CSH:  nxt_ph = (src_t[11:8] != 0) ? PH_AH : PH_IDLE;
      default: nxt_ph = PH_IDLE;
    endcase
    case (nxt_ph)
      PH_ASU:  nxt_cnt = CNT_W'(src_t[31:28]) - 1'b1;
      PH_CSU:  nxt_cnt = CNT_W'(src_t[27:24]) - 1'b1;
      PH_ACC:  nxt_cnt = CNT_W'(src_t[20:16]);
      PH_CSH:  nxt_cnt = CNT_W'(src_t[15:12]) - 1'b1;
      PH_AH:   nxt_cnt = CNT_W'(src_t[11:8]) - 1'b1;
      default: nxt_cnt = '0;
    endcase
  end

  assign advance = (cnt_q == 0) && !(ph_q == PH_ACC && attr_l[2] && mem_wait);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_q    <= '0;
      for (int n = 0; n < NBANK; n++) tword_q[n] <= RESET_TIMING;
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      tim_l     <= RESET_TIMING;
      attr_l    <= '0;
      bank_l    <= '0;
      wr_l      <= 1'b0;
      be_l      <= '0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_we) begin
        if (cfg_addr == CFG_AW'(ATTR_OFS)) attr_q <= cfg_wdata[4*NBANK-1:0];
        for (int n = 0; n < NBANK; n++)
          if (cfg_addr == CFG_AW'(TIMING_OFS + 4*n)) tword_q[n] <= cfg_wdata;
      end
      if (ph_q == PH_IDLE) begin
        if (req_valid) begin
          if (req_hit) begin
            ph_q     <= nxt_ph;
            cnt_q    <= nxt_cnt;
            tim_l    <= src_t;
            attr_l   <= req_attr;
            bank_l   <= req_bank;
            wr_l     <= req_write;
            be_l     <= req_be;
            mem_addr <= req_attr[1] ? req_addr[WIN_BITS-1:0]
                                    : {1'b0, req_addr[WIN_BITS-1:1]};
            mem_dout <= req_attr[0] ? req_wdata : {{HALF{1'b0}}, req_wdata[HALF-1:0]};
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
          end
        end
      end else if (!advance) begin
        if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      end else begin
        ph_q  <= nxt_ph;
        cnt_q <= nxt_cnt;
        if (ph_q == PH_ACC && !wr_l)
          rsp_rdata <= attr_l[0] ? mem_din : {{HALF{1'b0}}, mem_din[HALF-1:0]};
        if (nxt_ph == PH_IDLE) rsp_valid <= 1'b1;
      end
    end
  end

  assign req_ready   = ph_q == PH_IDLE;
  assign cs_on       = ph_q == PH_CSU || ph_q == PH_ACC || ph_q == PH_CSH;
  assign mem_cs_n    = cs_on ? ~(NBANK'(1) << bank_l) : '1;
  assign mem_oe_n    = !(ph_q == PH_ACC && !wr_l);
  assign mem_we_n    = !(ph_q == PH_ACC && wr_l);
  assign mem_dout_en = cs_on && wr_l;
  assign mem_be_n    = (cs_on && attr_l[3]) ? ~be_l : '1;

  AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R2
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != '1) && ($past(mem_cs_n) != '1)) |-> $stable(mem_addr)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en); // R6
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_wait && attr_l[2]) |=> !mem_oe_n); // R9
  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n == '1) |-> (mem_be_n == '1)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1) |-> !req_ready); // R12
endmodule

// File: tb/static_bus_timer_tb_top.sv
module static_bus_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid, mem_oe_n, mem_we_n, mem_dout_en;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dout, mem_din;
  logic [1:0]  req_be = '0, mem_be_n;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_wait = 1'b0;

  int checks = 0, errors = 0;
  logic [15:0] attr_sh = '0;
  int m_cs_fall, m_str_fall, m_str_last, m_cs_last, m_rsp;
  logic [3:0]  m_cs_seen;
  logic [23:0] m_addr;
  logic [15:0] m_dout, m_rdata;
  logic [1:0]  m_be;
  logic        m_drive_ok, m_be_ok, m_oe_seen;

  always #10 clk = ~clk;

  assign mem_din = mem_oe_n ? 16'h0000 : (mem_addr[15:0] ^ 16'hA5C3);

  static_bus_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait));

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_attr(int bank, logic [3:0] nib);
    attr_sh[4*bank +: 4] = nib;
    cfg_write(8'h00, {16'h0, attr_sh});
  endtask

  task automatic run(logic [31:0] a, logic wr, logic [15:0] wd, logic [1:0] be,
                     logic hold_wait, int wait_until,
                     int inj_k, logic [7:0] inj_a, logic [31:0] inj_d);
    int slow;
    bit done;
    slow = 0; done = 0;
    m_cs_fall = 0; m_str_fall = 0; m_str_last = 0; m_cs_last = 0; m_rsp = 0;
    m_cs_seen = '0; m_addr = '0; m_dout = '0; m_rdata = '0; m_be = '1;
    m_drive_ok = 1'b1; m_be_ok = 1'b1; m_oe_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_be = be;
    mem_wait = hold_wait;
    @(posedge clk);
    for (int k = 1; k <= 300 && !done; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      cfg_we = (k == inj_k); cfg_addr = inj_a; cfg_wdata = inj_d;
      if (!mem_oe_n) m_oe_seen = 1'b1;
      if (!mem_oe_n || !mem_we_n) begin
        slow++;
        if (slow == 1) begin
          m_str_fall = k; m_addr = mem_addr; m_dout = mem_dout; m_be = mem_be_n;
        end
        m_str_last = k;
      end
      mem_wait = hold_wait && (slow <= wait_until);
      if (mem_cs_n != 4'hF) begin
        if (m_cs_fall == 0) m_cs_fall = k;
        m_cs_last = k;
        m_cs_seen = m_cs_seen | ~mem_cs_n;
        if (wr && !mem_dout_en) m_drive_ok = 1'b0;
      end else if (mem_be_n != 2'b11) m_be_ok = 1'b0;
      if (rsp_valid) begin
        m_rsp = k; m_rdata = rsp_rdata; done = 1;
      end
    end
    cfg_we = 1'b0; mem_wait = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "cs_n", mem_cs_n, 4'hF);
    chk("R1", "oe_n/we_n", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R1", "be_n", mem_be_n, 2'b11);
    chk("R1", "dout_en", mem_dout_en, 0);
    chk("R1", "ready/rsp", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_default;
    run(32'h0400_0246, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R14", "default rsp", m_rsp, 65);
    chk("R3", "cs fall", m_cs_fall, 9);
    chk("R3", "oe fall", m_str_fall, 17);
    chk("R3", "oe last", m_str_last, 48);
    chk("R3", "cs last", m_cs_last, 56);
    chk("R2", "bank0 only", m_cs_seen, 4'b0001);
    chk("R8", "halfword addr", m_addr, 24'h123);
    chk("R7", "8-bit read", m_rdata, 16'h00E0);
  endtask

  task automatic t_presets;
    cfg_write(8'h08, 32'h111B_1100);
    cfg_write(8'h0C, 32'h110B_1100);
    set_attr(1, 4'h1);
    set_attr(2, 4'h1);
    run(32'h0500_0010, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R14", "preset 32 rsp", m_rsp, 33);
    chk("R4", "oe fall", m_str_fall, 3);
    chk("R4", "oe last", m_str_last, 30);
    chk("R4", "cs last", m_cs_last, 31);
    chk("R2", "bank1 only", m_cs_seen, 4'b0010);
    chk("R7", "16-bit read", m_rdata, 16'hA5CB);
    run(32'h0600_0000, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R14", "preset 16 rsp", m_rsp, 17);
    chk("R2", "bank2 only", m_cs_seen, 4'b0100);
  endtask

  task automatic t_zero;
    cfg_write(8'h10, 32'h0000_0000);
    set_attr(3, 4'h1);
    run(32'h0700_0004, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R5", "all-zero timings", {m_cs_fall[7:0], m_str_fall[7:0], m_str_last[7:0], m_rsp[7:0]}, 32'h01010102);
    chk("R2", "bank3 only", m_cs_seen, 4'b1000);
    cfg_write(8'h10, 32'h0203_0100);
    run(32'h0700_0004, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R5", "cs fall no setup", m_cs_fall, 1);
    chk("R5", "oe window", {m_str_fall[7:0], m_str_last[7:0]}, 16'h0306);
    chk("R5", "no cs hold", m_cs_last, 6);
    chk("R5", "rsp", m_rsp, 8);
  endtask

  task automatic t_write;
    set_attr(1, 4'h9);
    run(32'h0500_0020, 1, 16'hBEEF, 2'b10, 0, 0, 0, 0, 0);
    chk("R6", "we window", {m_str_fall[7:0], m_str_last[7:0]}, 16'h031E);
    chk("R6", "oe stays high", m_oe_seen, 0);
    chk("R6", "data driven while cs low", m_drive_ok, 1);
    chk("R6", "write data", m_dout, 16'hBEEF);
    chk("R6", "rsp", m_rsp, 33);
    chk("R10", "lanes on", m_be, 2'b01);
    chk("R10", "lanes idle high", m_be_ok, 1);
    run(32'h0400_0000, 1, 16'hBEEF, 2'b01, 0, 0, 0, 0, 0);
    chk("R7", "8-bit write data", m_dout, 16'h00EF);
    chk("R10", "lanes off", {m_be, m_be_ok}, 3'b111);
  endtask

  task automatic t_byteaddr;
    set_attr(2, 4'h3);
    run(32'h0600_0046, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R8", "byte addr", m_addr, 24'h46);
    chk("R8", "byte addr read", m_rdata, 16'hA585);
  endtask

  task automatic t_wait;
    set_attr(2, 4'h7);
    run(32'h0600_0000, 0, 0, 2'b11, 1, 14, 0, 0, 0);
    chk("R9", "stretched oe", {m_str_fall[7:0], m_str_last[7:0]}, 16'h0311);
    chk("R9", "stretched rsp", m_rsp, 20);
    run(32'h0500_0000, 0, 0, 2'b11, 1, 999, 0, 0, 0);
    chk("R9", "wait ignored oe last", m_str_last, 30);
    chk("R9", "wait ignored rsp", m_rsp, 33);
  endtask

  task automatic t_inflight;
    run(32'h0600_0000, 0, 0, 2'b11, 0, 0, 3, 8'h0C, 32'h881F_8800);
    chk("R12", "in-flight keeps timing", m_rsp, 17);
    run(32'h0600_0000, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R12", "next cycle uses new timing", m_rsp, 65);
  endtask

  task automatic t_cfg_ignore;
    cfg_write(8'h0C, 32'h11EB_11FF);
    cfg_write(8'h14, 32'h0000_0000);
    cfg_write(8'h0E, 32'h0000_0000);
    cfg_write(8'h40, 32'h0000_0000);
    run(32'h0600_0046, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R4", "spare bits ignored", m_rsp, 17);
    chk("R11", "stray offsets ignored", {m_str_fall[7:0], m_str_last[7:0]}, 16'h030E);
    chk("R11", "attr untouched", m_addr, 24'h46);
  endtask

  task automatic t_outwin;
    run(32'h0800_0000, 0, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R13", "above windows", {m_rsp[7:0], 4'h0, m_cs_seen}, 16'h0100);
    chk("R13", "zero data", m_rdata, 0);
    run(32'h0300_0000, 1, 16'h1234, 2'b11, 0, 0, 0, 0, 0);
    chk("R13", "below windows", {m_rsp[7:0], 4'h0, m_cs_seen}, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_presets();
    t_zero();
    t_write();
    t_byteaddr();
    t_wait();
    t_inflight();
    t_cfg_ignore();
    t_outwin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule